// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level translation table that sits in a memory holding 64-bit words. A caller hands over a virtual address together with the byte address of the root (outer) table. The walker then makes two memory reads, strictly one after the other. The first read fetches the outer entry, which points to an inner table. The second read fetches the inner entry, which holds the page frame. The walker returns the frame joined with the page offset. If either entry is marked absent, it returns a fault instead, tagged with the level at which the walk stopped.

The memory port is a plain read request/response pair. A request is held until the memory accepts it. The response may come back any number of cycles later. Only one walk is in progress at a time. The walker refuses new work until it has given its one-cycle result.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready_o` is 1, and both `mem_req_valid_o` and `rsp_valid_o` are 0.
- R2: The virtual address is split into three fields: the outer index in bits 31:22, the inner index in bits 21:12 and the page offset in bits 11:0. The first memory read goes to the root base plus the outer index times 8.
- R3: Entry bits 51:12 hold a 4 KiB-aligned address. The second read goes to that address from the outer entry, plus the inner index times 8.
- R4: A walk makes at most two reads, outer then inner, with at most one read outstanding. While `mem_req_ready_i` is low, a pending read holds its valid and its address.
- R5: Entry bit 0 is the present flag. When both entries are present, `rsp_paddr_o` equals inner-entry bits 51:12 followed by the unchanged 12-bit offset, and `rsp_fault_o` is 0.
- R6: If the outer entry is absent, the response has `rsp_fault_o`=1 and `rsp_fault_lvl_o`=0, and no inner read is made.
- R7: If the inner entry is absent, the response has `rsp_fault_o`=1 and `rsp_fault_lvl_o`=1, after both reads.
- R8: Entry bits 63:52 and 11:1 have no effect on the result.
- R9: `rsp_valid_o` is high for exactly one cycle. In the next cycle `req_ready_o` is 1 again.
- R10: `req_ready_o` stays 0 from the moment a request is accepted until the response. Requests offered during that time are ignored.
- R11: Each memory response delay counts once per level. Adding N cycles of read latency makes the walk 2N cycles longer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Translation request offered |
| req_ready_o | output | 1 | Walker idle, request taken this cycle if valid |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_root_i | input | 52 | Byte address of the outer table |
| mem_req_valid_o | output | 1 | Memory read request |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | 52 | Byte address of the entry to read |
| mem_rsp_valid_i | input | 1 | Read data returned |
| mem_rsp_data_i | input | 64 | Returned entry |
| rsp_valid_o | output | 1 | One-cycle translation result |
| rsp_fault_o | output | 1 | Result is a fault |
| rsp_fault_lvl_o | output | 1 | Level of the absent entry: 0 outer, 1 inner |
| rsp_paddr_o | output | 52 | Translated physical address |

## Verification
The walker is driven with several virtual addresses. The first has mixed index and offset fields, which would expose a swapped or shifted field. Two more sit at index 0 with the largest offset and at index 1023 with a zero offset, which exposes truncated scaling or a wrong slice. Entries are also written with every ignored bit set, so that any leak of those bits into an address shows up. Absent-entry cases at each level tell the two fault levels apart and count the reads made. Runs with different response delays and with stalled request acceptance show that the delay is paid once per level and that a stalled read is held.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_OUTER,
    ST_WT_OUTER,
    ST_RD_INNER,
    ST_WT_INNER,
    ST_DONE,
    ST_FAULT
  } walk_state_e;

  localparam int unsigned LEVELS = 2;
endpackage

// File: rtl/ptw_ent_addr.sv
module ptw_ent_addr #(
  parameter int unsigned PA_W    = 52,
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned ENT_BYTES = 8
) (
  input  logic [PA_W-1:0]  base_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [PA_W-1:0]  addr_o
);
  localparam int unsigned ENT_SH = $clog2(ENT_BYTES);

  assign addr_o = base_i + (PA_W'(idx_i) << ENT_SH);
endmodule

// File: rtl/ptw_pte_dec.sv
module ptw_pte_dec #(
  parameter int unsigned PTE_W = 64,
  parameter int unsigned PA_W  = 52,
  parameter int unsigned OFF_W = 12
) (
  input  logic [PTE_W-1:0]      pte_i,
  output logic                  present_o,
  output logic [PA_W-OFF_W-1:0] ppn_o
);
  logic unused_pte_bits;

  assign present_o = pte_i[0];
  assign ppn_o     = pte_i[PA_W-1:OFF_W];
  // status and reserved bits carry no meaning here
  assign unused_pte_bits = ^{pte_i[PTE_W-1:PA_W], pte_i[OFF_W-1:1]};
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        mem_req_ready_i,
  input  logic        mem_rsp_valid_i,
  input  logic        pte_present_i,
  output walk_state_e state_o
);
  walk_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (req_valid_i) state_d = ST_RD_OUTER;
      ST_RD_OUTER: if (mem_req_ready_i) state_d = ST_WT_OUTER;
      ST_WT_OUTER: if (mem_rsp_valid_i) state_d = pte_present_i ? ST_RD_INNER : ST_FAULT;
      ST_RD_INNER: if (mem_req_ready_i) state_d = ST_WT_INNER;
      ST_WT_INNER: if (mem_rsp_valid_i) state_d = pte_present_i ? ST_DONE : ST_FAULT;
      ST_DONE, ST_FAULT: state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned PA_W      = 52,
  parameter int unsigned PTE_W     = 64,
  parameter int unsigned ENT_BYTES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic [PA_W-1:0]  req_root_i,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [PA_W-1:0]  mem_req_addr_o,
  input  logic             mem_rsp_valid_i,
  input  logic [PTE_W-1:0] mem_rsp_data_i,
  output logic             rsp_valid_o,
  output logic             rsp_fault_o,
  output logic             rsp_fault_lvl_o,
  output logic [PA_W-1:0]  rsp_paddr_o
);
  localparam int unsigned IDX_W = (VA_W - OFF_W) / LEVELS;
  localparam int unsigned PPN_W = PA_W - OFF_W;

  walk_state_e state;
  logic [VA_W-1:0]  vaddr_q;
  logic [PA_W-1:0]  root_q, inner_base_q;
  logic [PPN_W-1:0] frame_q;
  logic             fault_lvl_q;
  logic             pte_present;
  logic [PPN_W-1:0] pte_ppn;

  logic [PA_W-1:0]  lvl_base [LEVELS];
  logic [IDX_W-1:0] lvl_idx  [LEVELS];
  logic [PA_W-1:0]  lvl_addr [LEVELS];

  ptw_ctrl u_ctrl (
    .clk_i,
    .rst_ni,
    .req_valid_i,
    .mem_req_ready_i,
    .mem_rsp_valid_i,
    .pte_present_i (pte_present),
    .state_o       (state)
  );

  ptw_pte_dec #(.PTE_W(PTE_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_dec (
    .pte_i     (mem_rsp_data_i),
    .present_o (pte_present),
    .ppn_o     (pte_ppn)
  );

  assign lvl_base[0] = root_q;
  assign lvl_base[1] = inner_base_q;

  // level 0 takes the top index field, the last level the one above the offset
  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    assign lvl_idx[g] = vaddr_q[VA_W-1-g*IDX_W -: IDX_W];
    ptw_ent_addr #(.PA_W(PA_W), .IDX_W(IDX_W), .ENT_BYTES(ENT_BYTES)) u_addr (
      .base_i (lvl_base[g]),
      .idx_i  (lvl_idx[g]),
      .addr_o (lvl_addr[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vaddr_q      <= '0;
      root_q       <= '0;
      inner_base_q <= '0;
      frame_q      <= '0;
      fault_lvl_q  <= 1'b0;
    end else begin
      if (state == ST_IDLE && req_valid_i) begin
        vaddr_q <= req_vaddr_i;
        root_q  <= req_root_i;
      end
      if (state == ST_WT_OUTER && mem_rsp_valid_i) begin
        inner_base_q <= {pte_ppn, {OFF_W{1'b0}}};
        fault_lvl_q  <= 1'b0;
      end
      if (state == ST_WT_INNER && mem_rsp_valid_i) begin
        frame_q     <= pte_ppn;
        fault_lvl_q <= 1'b1;
      end
    end
  end

  assign req_ready_o     = (state == ST_IDLE);
  assign mem_req_valid_o = (state == ST_RD_OUTER) || (state == ST_RD_INNER);
  assign mem_req_addr_o  = (state == ST_RD_INNER) ? lvl_addr[1] : lvl_addr[0];
  assign rsp_valid_o     = (state == ST_DONE) || (state == ST_FAULT);
  assign rsp_fault_o     = (state == ST_FAULT);
  assign rsp_fault_lvl_o = fault_lvl_q;
  assign rsp_paddr_o     = {frame_q, vaddr_q[OFF_W-1:0]};

  // R4
  mem_req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  // R9
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o);

  // R10
  busy_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !req_ready_o);

  // R10
  accept_starts_walk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> mem_req_valid_o && !req_ready_o);

  // R4
  no_req_while_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !mem_req_valid_o);
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [51:0] req_root = '0;
  logic        mem_req_valid;
  logic        mem_ready;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        rsp_valid, rsp_fault, rsp_lvl;
  logic [51:0] rsp_paddr;

  always #5 clk = ~clk;

  pt_walker dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_vaddr), .req_root_i(req_root),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_ready),
    .mem_req_addr_o(mem_req_addr),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_data_i(mem_rsp_data),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault),
    .rsp_fault_lvl_o(rsp_lvl), .rsp_paddr_o(rsp_paddr)
  );

  // behavioural memory
  logic [63:0] mem_q [logic [51:0]];
  logic [51:0] addr_log [0:7];
  int          mem_reads = 0;
  int          mem_lat = 0, mem_gap = 0, gap_cnt = 0, dly = 0;
  logic        pend = 1'b0;
  logic [51:0] pend_addr = '0;

  assign mem_ready = (gap_cnt >= mem_gap);

  function automatic logic [63:0] rd(input logic [51:0] a);
    return mem_q.exists(a) ? mem_q[a] : 64'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      pend          <= 1'b0;
      gap_cnt       <= 0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_ready) begin
        pend      <= 1'b1;
        pend_addr <= mem_req_addr;
        dly       <= mem_lat;
        addr_log[mem_reads % 8] <= mem_req_addr;
        mem_reads <= mem_reads + 1;
        gap_cnt   <= 0;
      end else if (mem_req_valid) begin
        gap_cnt <= gap_cnt + 1;
      end
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= rd(pend_addr);
          pend          <= 1'b0;
        end else begin
          dly <= dly - 1;
        end
      end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  localparam logic [63:0] JUNK = 64'hFFF0_0000_0000_0FFE;

  function automatic logic [51:0] outer_addr(input logic [51:0] b, input logic [31:0] va);
    return b + {39'h0, va[31:22], 3'b000};
  endfunction
  function automatic logic [51:0] inner_addr(input logic [51:0] ib, input logic [31:0] va);
    return {ib[51:12], 12'h0} + {39'h0, va[21:12], 3'b000};
  endfunction

  task automatic map(input logic [51:0] b, input logic [31:0] va, input logic [51:0] ib,
                     input logic [39:0] frame, input bit o_pres, input bit i_pres, input bit junk);
    mem_q[outer_addr(b, va)] = {12'h0, ib[51:12], 11'h0, o_pres} | (junk ? JUNK : 64'h0);
    mem_q[inner_addr(ib, va)] = {12'h0, frame, 11'h0, i_pres} | (junk ? JUNK : 64'h0);
  endtask

  // walk results
  logic        r_fault, r_lvl, r_after_ok, r_busy_ok;
  logic [51:0] r_pa, r_a0, r_a1;
  int          r_reads, r_cycles;

  task automatic run_walk(input logic [31:0] va, input logic [51:0] b,
                          input int lat, input int gap, input bit poke);
    int start;
    @(negedge clk);
    mem_lat = lat; mem_gap = gap;
    start = mem_reads;
    req_valid = 1'b1; req_vaddr = va; req_root = b;
    @(negedge clk);
    if (poke) begin req_vaddr = ~va; req_root = b + 52'h8000; end
    else req_valid = 1'b0;
    r_cycles = 1; r_busy_ok = 1'b1;
    while (!rsp_valid && r_cycles < 500) begin
      if (req_ready) r_busy_ok = 1'b0;
      @(negedge clk);
      r_cycles++;
    end
    r_fault = rsp_fault; r_lvl = rsp_lvl; r_pa = rsp_paddr;
    req_valid = 1'b0;
    if (!rsp_valid) check(1'b0, "R11 walk timeout", 0, 1);
    @(negedge clk);
    r_after_ok = !rsp_valid && req_ready;
    r_reads = mem_reads - start;
    r_a0 = addr_log[start % 8];
    r_a1 = addr_log[(start + 1) % 8];
  endtask

  task automatic t_reset;
    check(req_ready === 1'b1, "R1 req_ready after reset", req_ready, 1);
    check(mem_req_valid === 1'b0, "R1 mem_req_valid after reset", mem_req_valid, 0);
    check(rsp_valid === 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
  endtask

  task automatic t_basic;
    logic [31:0] va = 32'hFC51_908B;
    logic [51:0] b = 52'h0_0001_0000, ib = 52'h0_0023_0000;
    map(b, va, ib, 40'h152, 1, 1, 0);
    run_walk(va, b, 0, 0, 0);
    check(r_reads == 2, "R4 read count", r_reads, 2);
    check(r_a0 == outer_addr(b, va), "R2 outer entry address", r_a0, outer_addr(b, va));
    check(r_a1 == inner_addr(ib, va), "R3 inner entry address", r_a1, inner_addr(ib, va));
    check(!r_fault && r_pa == 52'h15208B, "R5 translated address", r_pa, 52'h15208B);
    check(r_after_ok, "R9 single-cycle response", r_after_ok, 1);
  endtask

  task automatic t_corners;
    logic [31:0] va0 = 32'h0000_0FFF, va1 = 32'hFFFF_F000;
    logic [51:0] b = 52'h0_0040_0000;
    map(b, va0, 52'h0_0050_0000, 40'hAB_CDEF_0123, 1, 1, 0);
    map(b, va1, 52'h0_0060_0000, 40'h00_0000_0001, 1, 1, 0);
    run_walk(va0, b, 2, 1, 0);
    check(r_a0 == b, "R2 index zero address", r_a0, b);
    check(!r_fault && r_pa == {40'hAB_CDEF_0123, 12'hFFF}, "R5 low corner", r_pa, {40'hAB_CDEF_0123, 12'hFFF});
    run_walk(va1, b, 2, 1, 0);
    check(r_a0 == b + 52'h1FF8, "R2 index 1023 address", r_a0, b + 52'h1FF8);
    check(r_a1 == 52'h0_0060_1FF8, "R3 index 1023 address", r_a1, 52'h0_0060_1FF8);
    check(!r_fault && r_pa == 52'h1000, "R5 high corner", r_pa, 52'h1000);
  endtask

  task automatic t_junk;
    logic [31:0] va = 32'h1234_5678;
    logic [51:0] b = 52'h0_0070_0000, ib = 52'h0_0080_0000;
    map(b, va, ib, 40'h33_4455_6677, 1, 1, 1);
    run_walk(va, b, 1, 0, 0);
    check(r_a1 == inner_addr(ib, va), "R8 ignored bits in outer entry", r_a1, inner_addr(ib, va));
    check(!r_fault && r_pa == {40'h33_4455_6677, 12'h678}, "R8 ignored bits in inner entry",
          r_pa, {40'h33_4455_6677, 12'h678});
  endtask

  task automatic t_outer_fault;
    logic [31:0] va = 32'h8000_1234;
    logic [51:0] b = 52'h0_0090_0000;
    map(b, va, 52'h0_00A0_0000, 40'h1, 0, 1, 1);
    run_walk(va, b, 1, 0, 0);
    check(r_fault === 1'b1, "R6 outer fault flag", r_fault, 1);
    check(r_lvl === 1'b0, "R6 outer fault level", r_lvl, 0);
    check(r_reads == 1, "R6 no inner read", r_reads, 1);
    check(r_after_ok, "R9 ready after fault", r_after_ok, 1);
  endtask

  task automatic t_inner_fault;
    logic [31:0] va = 32'h0040_3ABC;
    logic [51:0] b = 52'h0_00B0_0000;
    map(b, va, 52'h0_00C0_0000, 40'h77, 1, 0, 0);
    run_walk(va, b, 0, 2, 0);
    check(r_fault === 1'b1 && r_lvl === 1'b1, "R7 inner fault level", {r_fault, r_lvl}, 2'b11);
    check(r_reads == 2, "R7 reads before inner fault", r_reads, 2);
  endtask

  task automatic t_busy;
    logic [31:0] va = 32'h5555_5AAA;
    logic [51:0] b = 52'h0_00D0_0000;
    map(b, va, 52'h0_00E0_0000, 40'h9_8765, 1, 1, 0);
    run_walk(va, b, 3, 2, 1);
    check(r_busy_ok, "R10 ready low while busy", r_busy_ok, 1);
    check(!r_fault && r_pa == {40'h9_8765, 12'hAAA}, "R10 busy request ignored", r_pa, {40'h9_8765, 12'hAAA});
    check(r_reads == 2, "R10 no extra reads", r_reads, 2);
    check(r_after_ok, "R9 ready after busy walk", r_after_ok, 1);
  endtask

  task automatic t_latency;
    logic [31:0] va = 32'hFC51_908B;
    logic [51:0] b = 52'h0_0001_0000;
    int c0;
    run_walk(va, b, 0, 0, 0);
    c0 = r_cycles;
    run_walk(va, b, 4, 0, 0);
    check(r_cycles - c0 == 8, "R11 latency per level", r_cycles - c0, 8);
    check(r_pa == 52'h15208B, "R11 result with latency", r_pa, 52'h15208B);
    run_walk(va, b, 2, 4, 0);
    check(r_pa == 52'h15208B && r_reads == 2, "R4 stalled request", r_pa, 52'h15208B);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_corners();
    t_junk();
    t_outer_fault();
    t_inner_fault();
    t_busy();
    t_latency();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule